// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block holds four 8-bit general-purpose registers for a small single-cycle datapath. It offers two read ports, each with its own 2-bit register select. Both ports are combinational, so read data follows the selects within the same cycle. It has one write port that loads on the rising clock edge. The write port has no address of its own. It stores into whichever register the first read port selects, so the first source operand is also the destination of the result.

A write happens only when the write enable is high. Instructions that produce no result, such as branches, hold the enable low and leave every register as it was. All registers share the processor's single clock. A synchronous, active-high reset clears the whole bank to zero.

Top module: `regbank2r1w`

## Requirements
- R1: The bank holds four registers selected by a 2-bit code, where value 0 picks r0, 1 picks r1, 2 picks r2 and 3 picks r3. The first read output shows the register that the destination/source-A select names.
- R2: The second read port has its own 2-bit select and works independently of the first. When both selects name the same register, both outputs carry the same value.
- R3: When the write enable is high at a rising clock edge, all 8 bits of the write data go into the register named by the destination/source-A select. No other register changes.
- R4: When the write enable is low at a rising clock edge, no register changes, whatever the write data and selects are.
- R5: When reset is high at a rising clock edge, all four registers become 0. Reset takes priority over a write in the same cycle.
- R6: Both read outputs are combinational. A change of select shows on the output without a clock edge. A pending write is not visible before the edge, so during a write cycle the first port still returns the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared processor clock; rising edge is active |
| rst | input | 1 | Synchronous active-high clear of all registers |
| dst_sel | input | 2 | Select for read port A; also the write target |
| src_sel | input | 2 | Select for read port B |
| wr_val | input | 8 | Data to store |
| wr_en | input | 1 | Store enable |
| rd_dst_val | output | 8 | Contents of the register named by dst_sel |
| rd_src_val | output | 8 | Contents of the register named by src_sel |

## Verification
The embedded properties are checked on every clock. They cover the following:
- At most one register is strobed per edge, and none while the enable is low.
- Each register loads exactly the data presented, or keeps its value when not strobed.
- The bank reads zero after a reset.
- Two ports with equal selects agree.
- Port A keeps a steady value when nothing was written and its select did not move.

Some behaviour can only be shown by the bench's scenarios against a shadow model:
- The combinational response to a select change between clock edges.
- The old value returned during a write cycle.
- Reset winning over a simultaneous write.
- Full sweeps of both ports across every register with a toggling enable.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Default geometry of the bank
    localparam int unsigned RB_DATA_W = 8;
    localparam int unsigned RB_DEPTH  = 4;
    localparam int unsigned RB_SEL_W  = (RB_DEPTH > 1) ? $clog2(RB_DEPTH) : 1;

    // Symbolic names of the general-purpose registers
    typedef enum logic [RB_SEL_W-1:0] {
        RB_R0 = 2'd0,
        RB_R1 = 2'd1,
        RB_R2 = 2'd2,
        RB_R3 = 2'd3
    } rb_reg_e;

    // True when a select code names entry idx
    function automatic logic rb_hit(input logic [RB_SEL_W-1:0] sel, input int unsigned idx);
        return (int'(sel) == int'(idx));
    endfunction

endpackage

// File: rtl/rb_cell.sv
module rb_cell #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= d;
    end

    // R3: a strobed cell holds exactly the presented data afterwards
    p_cell_load_r3: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(d)));

    // R4: an unstrobed cell keeps its contents
    p_cell_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));

endmodule

// File: rtl/rb_wr_decode.sv
module rb_wr_decode #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [DEPTH-1:0] strobe
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_strb
        assign strobe[i] = en && (sel == SEL_W'(i));
    end

    // R3: a write touches no more than one register
    p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));

    // R4: nothing is strobed while the enable is low
    p_strobe_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !en |-> (strobe == '0));

endmodule

// File: rtl/rb_rd_mux.sv
module rb_rd_mux #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned SEL_W = 2
) (
    input  logic [W-1:0]     regs [DEPTH],
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     q
);

    always_comb begin
        q = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i))
                q = regs[i];
        end
    end

endmodule

// File: rtl/regbank2r1w.sv
module regbank2r1w
    import regbank_pkg::*;
#(
    parameter int unsigned DATA_W = RB_DATA_W,
    parameter int unsigned DEPTH  = RB_DEPTH,
    localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  dst_sel,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_dst_val,
    output logic [DATA_W-1:0] rd_src_val
);

    logic [DEPTH-1:0]  ld_strobe;
    logic [DATA_W-1:0] bank [DEPTH];

    rb_wr_decode #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .en     (wr_en),
        .sel    (dst_sel),
        .strobe (ld_strobe)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        rb_cell #(.W(DATA_W)) u_cell (
            .clk (clk),
            .rst (rst),
            .ld  (ld_strobe[i]),
            .d   (wr_val),
            .q   (bank[i])
        );
    end

    rb_rd_mux #(.W(DATA_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_rd_dst (
        .regs (bank),
        .sel  (dst_sel),
        .q    (rd_dst_val)
    );

    rb_rd_mux #(.W(DATA_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_rd_src (
        .regs (bank),
        .sel  (src_sel),
        .q    (rd_src_val)
    );

    // R5: after a reset edge both ports read zero
    p_reset_clears_r5: assert property (@(posedge clk)
        rst |=> (rd_dst_val == '0 && rd_src_val == '0));

    // R2: equal selects give equal data on both ports
    p_ports_agree_r2: assert property (@(posedge clk) disable iff (rst)
        (dst_sel == src_sel) |-> (rd_dst_val == rd_src_val));

    // R3: the written value appears on port A once the edge has passed
    p_write_visible_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en ##1 $stable(dst_sel) |-> (rd_dst_val == $past(wr_val)));

    // R4: no write and a steady select keep port A steady
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en ##1 $stable(dst_sel) |-> $stable(rd_dst_val));

endmodule

// File: tb/regbank2r1w_test.sv
module regbank2r1w_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] dst_sel = '0;
    logic [1:0] src_sel = '0;
    logic [7:0] wr_val = '0;
    logic       wr_en = 1'b0;
    logic [7:0] rd_dst_val;
    logic [7:0] rd_src_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] shadow [4];

    always #5 clk = ~clk;

    regbank2r1w uut (
        .clk        (clk),
        .rst        (rst),
        .dst_sel    (dst_sel),
        .src_sel    (src_sel),
        .wr_val     (wr_val),
        .wr_en      (wr_en),
        .rd_dst_val (rd_dst_val),
        .rd_src_val (rd_src_val)
    );

    function automatic logic [7:0] expect_rd(input logic [1:0] s);
        return shadow[s];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle; check reads before the edge, then update the shadow
    task automatic step(input bit we, input logic [1:0] a, input logic [1:0] b,
                        input logic [7:0] d, input bit r, input string req);
        @(negedge clk);
        rst = r; wr_en = we; dst_sel = a; src_sel = b; wr_val = d;
        #1;
        chk({req, "/R1/R6 port A"}, rd_dst_val, expect_rd(a));
        chk({req, "/R2 port B"}, rd_src_val, expect_rd(b));
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < 4; k++) shadow[k] = 8'h00;
        end else if (we) begin
            shadow[a] = d;
        end
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 4; k++)
            step(1'b0, 2'(k), 2'(3 - k), 8'hFF, 1'b0, req);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) shadow[k] = 8'h00;
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_all("R5 reset state");

        // R3/R4: toggle enable, sweep both selects, data rises by 8
        for (int i = 0; i < 32; i++)
            step(i[0] == 1'b0, 2'(i % 4), 2'((i / 4) % 4), 8'(i * 8), 1'b0, "R3 sweep");
        read_all("R4 after sweep");

        // R4: enable low with fresh data changes nothing
        for (int k = 0; k < 4; k++)
            step(1'b0, 2'(k), 2'(k), 8'h5A, 1'b0, "R4 idle");
        read_all("R4 idle readback");

        // R3: full-width patterns, only one register written
        step(1'b1, 2'd3, 2'd0, 8'hFF, 1'b0, "R3 ones");
        step(1'b1, 2'd0, 2'd3, 8'h80, 1'b0, "R3 msb");
        step(1'b0, 2'd3, 2'd3, 8'h00, 1'b0, "R2 same sel");
        read_all("R3 pattern readback");

        // R6: write cycle returns old value; select change without a clock
        step(1'b1, 2'd1, 2'd1, 8'hC3, 1'b0, "R6 old value");
        @(negedge clk);
        wr_en = 1'b0; dst_sel = 2'd1; src_sel = 2'd0;
        #1;
        chk("R6 after edge", rd_dst_val, 8'hC3);
        dst_sel = 2'd3; src_sel = 2'd1;
        #1;
        chk("R6 comb port A", rd_dst_val, expect_rd(2'd3));
        chk("R6 comb port B", rd_src_val, 8'hC3);

        // Random traffic against the shadow
        for (int i = 0; i < 400; i++)
            step(1'($urandom), 2'($urandom), 2'($urandom), 8'($urandom), 1'b0, "R3 random");
        read_all("R3 random readback");

        // R5: reset beats a simultaneous write
        step(1'b1, 2'd2, 2'd2, 8'hAA, 1'b1, "R5 reset vs write");
        read_all("R5 after reset");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule